// File: doc/BRIEF.md
# DRAM Idle-Driven Low-Power Sequencer

This block sits beside a DRAM controller and watches a single bus-idle flag in the DFI clock domain, which runs at half the DRAM clock rate. It counts consecutive idle cycles and steps the memory into deeper low-power states as configured thresholds pass. The states, from shallowest to deepest, are power-down, self-refresh, self-refresh with the controller clock gated, self-refresh power-down (LPDDR4 parts only) and full standby, in which every clock toward the controller, the PHY interface and the DRAM is stopped. Power-down and standby thresholds count raw DFI cycles. The three self-refresh thresholds count in units of 2^SHIFT cycles, which is 1024 with the default parameters.

Each entry is announced by a one-cycle strobe that carries the target state code, and the command path carries out the entry. Any non-idle cycle or an explicit wake request starts the exit. The clock enables come back first. One cycle later an exit strobe is issued, and the block stays busy until the command path acknowledges the exit. Thresholds and the DRAM type are captured only while the block is active. This lets software rewrite the threshold inputs at any time without disturbing a sequence that is already under way. The idle counter saturates at its maximum value and does not wrap.

Top module: `lp_idle_seq`

## Requirements
- R1: After reset, cur_state is 0 (active), ctl_clk_en and sys_clk_en are 1, and enter_req, exit_req and busy are 0.
- R2: With a nonzero pd_thr = N, state 1 (power-down) is entered on the clock edge after the idle count reaches N, which is the (N+1)-th consecutive idle edge. Fewer idle edges leave the block active.
- R3: The self-refresh (code 2), gated self-refresh (code 3) and self-refresh power-down (code 4) thresholds are compared against the idle count after a left shift by SHIFT. Standby (code 5) uses stby_thr unscaled.
- R4: One cycle after the block settles in code 3 or deeper, ctl_clk_en is 0. One cycle after it settles in code 5, sys_clk_en is also 0. The clocks are gated after the state request and never before it.
- R5: Code 4 is reachable only when dram_kind was 2 (LPDDR4) when the thresholds were captured. For kind 0 (DDR3) or kind 1 (LPDDR3), that level is skipped.
- R6: A threshold of zero disables its state.
- R7: When several thresholds have elapsed, the block holds the deepest enabled state among them, using the order 0 < 1 < 2 < 3 < 4 < 5. The state only deepens while idle continues.
- R8: Each state entry raises enter_req for exactly one cycle, with enter_state equal to the new cur_state.
- R9: When bus_idle is low or wake_req is high in a non-active state, both clock enables are 1 two edges later. exit_req pulses for one cycle on the following edge. busy stays 1 and cur_state keeps its value until exit_ack is seen, and cur_state then returns to 0. While wake_req is held, the idle count stays at zero.
- R10: The threshold and dram_kind inputs are captured only while the block is active and not busy. A change made during a low-power state has no effect until the block is back in the active state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | DFI-domain clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_idle | input | 1 | High when the memory bus is idle this cycle |
| wake_req | input | 1 | Forces an exit and holds the idle count at zero |
| pd_thr | input | THR_W | Power-down threshold, in raw cycles |
| sr_thr | input | SCL_W | Self-refresh threshold, in units of 2^SHIFT cycles |
| srg_thr | input | SCL_W | Threshold for self-refresh with controller clock gated, in units of 2^SHIFT cycles |
| srpd_thr | input | SCL_W | Self-refresh power-down threshold, in units of 2^SHIFT cycles |
| stby_thr | input | THR_W | Standby threshold, in raw cycles |
| dram_kind | input | 2 | Memory type: 0 DDR3, 1 LPDDR3, 2 LPDDR4 |
| exit_ack | input | 1 | Command path confirms that the exit is complete |
| enter_req | output | 1 | One-cycle strobe for a state entry |
| enter_state | output | 3 | State code that goes with enter_req |
| exit_req | output | 1 | One-cycle strobe requesting an exit |
| cur_state | output | 3 | Current state code |
| ctl_clk_en | output | 1 | Controller clock enable |
| sys_clk_en | output | 1 | Enable for the PHY-interface, PHY and DRAM clocks |
| busy | output | 1 | Exit in progress |

## Verification
The assertions take for granted that exit_ack is a response and never arrives on its own. They also assume that the command path has no say in how soon the block deepens its state, so two entry strobes may follow each other on back-to-back edges. The stimulus raises exit_ack only after exit_req has been seen, holds it for a single cycle and drops it before the next sequence starts. Thresholds are changed only while the block is active, except in the one case that checks the capture rule.

// File: rtl/lp_seq_pkg.sv
package lp_seq_pkg;

    typedef enum logic [2:0] {
        ST_ACTIVE = 3'd0,
        ST_PD     = 3'd1,
        ST_SR     = 3'd2,
        ST_SRG    = 3'd3,
        ST_SRPD   = 3'd4,
        ST_STBY   = 3'd5
    } lp_state_e;

    typedef enum logic [1:0] {
        PH_RUN     = 2'd0,
        PH_RESTORE = 2'd1,
        PH_ISSUE   = 2'd2,
        PH_WAIT    = 2'd3
    } lp_phase_e;

    typedef struct packed {
        logic ctl;
        logic sys;
    } clk_en_t;

    localparam logic [1:0] KIND_LP4 = 2'd2;
    localparam int         NUM_LVL  = 5;

    // levels 2..4 count in 2^SHIFT units, 1 and 5 in raw cycles
    function automatic bit lvl_scaled(input int lvl);
        return (lvl >= 2) && (lvl <= 4);
    endfunction

    function automatic clk_en_t clocks_for(input lp_state_e s);
        clk_en_t e;
        e.ctl = (s < ST_SRG);
        e.sys = (s != ST_STBY);
        return e;
    endfunction

endpackage

// File: rtl/lp_idle_cnt.sv
module lp_idle_cnt #(
    parameter int CNT_W = 18
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             count_en,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk) begin
        if (rst || !count_en) begin
            cnt <= '0;
        end else if (cnt != CNT_MAX) begin
            cnt <= cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/lp_level_pick.sv
module lp_level_pick
    import lp_seq_pkg::*;
#(
    parameter int THR_W = 16,
    parameter int SCL_W = 8,
    parameter int SHIFT = 10,
    parameter int CNT_W = 18
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [THR_W-1:0] pd_thr,
    input  logic [SCL_W-1:0] sr_thr,
    input  logic [SCL_W-1:0] srg_thr,
    input  logic [SCL_W-1:0] srpd_thr,
    input  logic [THR_W-1:0] stby_thr,
    input  logic [1:0]       dram_kind,
    input  logic [CNT_W-1:0] cnt,
    output lp_state_e        target,
    output logic [1:0]       kind_q
);
    logic [THR_W-1:0] raw_in [1:NUM_LVL];
    logic [SCL_W-1:0] scl_in [1:NUM_LVL];
    logic [CNT_W-1:0] lim_d  [1:NUM_LVL];
    logic [CNT_W-1:0] lim_q  [1:NUM_LVL];
    logic [NUM_LVL:1] en_d, en_q, hit;

    always_comb begin
        for (int i = 1; i <= NUM_LVL; i++) begin
            raw_in[i] = '0;
            scl_in[i] = '0;
        end
        raw_in[1] = pd_thr;
        scl_in[2] = sr_thr;
        scl_in[3] = srg_thr;
        scl_in[4] = srpd_thr;
        raw_in[5] = stby_thr;
    end

    for (genvar g = 1; g <= NUM_LVL; g++) begin : g_lvl
        if (lvl_scaled(g)) begin : g_scaled
            assign lim_d[g] = CNT_W'(scl_in[g]) << SHIFT;
            assign en_d[g]  = (scl_in[g] != '0);
        end else begin : g_raw
            assign lim_d[g] = CNT_W'(raw_in[g]);
            assign en_d[g]  = (raw_in[g] != '0);
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                lim_q[g] <= '0;
                en_q[g]  <= 1'b0;
            end else if (load) begin
                lim_q[g] <= lim_d[g];
                en_q[g]  <= en_d[g];
            end
        end

        if (g == int'(ST_SRPD)) begin : g_kind_gate
            assign hit[g] = en_q[g] && (kind_q == KIND_LP4) && (cnt >= lim_q[g]);
        end else begin : g_plain
            assign hit[g] = en_q[g] && (cnt >= lim_q[g]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            kind_q <= '0;
        end else if (load) begin
            kind_q <= dram_kind;
        end
    end

    always_comb begin
        target = ST_ACTIVE;
        for (int i = 1; i <= NUM_LVL; i++) begin
            if (hit[i]) begin
                target = lp_state_e'(3'(i));
            end
        end
    end
endmodule

// File: rtl/lp_state_ctrl.sv
module lp_state_ctrl
    import lp_seq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      bus_idle,
    input  logic      wake_req,
    input  logic      exit_ack,
    input  lp_state_e target,
    output lp_state_e state,
    output lp_phase_e phase,
    output logic      enter_req,
    output lp_state_e enter_state,
    output logic      exit_req,
    output clk_en_t   clk_en
);
    logic stop;
    assign stop = !bus_idle || wake_req;

    always_ff @(posedge clk) begin
        if (rst) begin
            state       <= ST_ACTIVE;
            phase       <= PH_RUN;
            enter_req   <= 1'b0;
            enter_state <= ST_ACTIVE;
            exit_req    <= 1'b0;
        end else begin
            enter_req <= 1'b0;
            exit_req  <= 1'b0;
            case (phase)
                PH_RUN: begin
                    if (stop) begin
                        if (state != ST_ACTIVE) begin
                            phase <= PH_RESTORE;
                        end
                    end else if (target > state) begin
                        state       <= target;
                        enter_req   <= 1'b1;
                        enter_state <= target;
                    end
                end
                PH_RESTORE: phase <= PH_ISSUE;
                PH_ISSUE: begin
                    exit_req <= 1'b1;
                    phase    <= PH_WAIT;
                end
                PH_WAIT: begin
                    if (exit_ack) begin
                        state <= ST_ACTIVE;
                        phase <= PH_RUN;
                    end
                end
                default: phase <= PH_RUN;
            endcase
        end
    end

    // enables trail the state by one edge; any exit phase forces them on
    always_ff @(posedge clk) begin
        if (rst) begin
            clk_en <= '{ctl: 1'b1, sys: 1'b1};
        end else if (phase == PH_RUN) begin
            clk_en <= clocks_for(state);
        end else begin
            clk_en <= '{ctl: 1'b1, sys: 1'b1};
        end
    end
endmodule

// File: rtl/lp_idle_seq.sv
module lp_idle_seq
    import lp_seq_pkg::*;
#(
    parameter int THR_W = 16,
    parameter int SCL_W = 8,
    parameter int SHIFT = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_idle,
    input  logic             wake_req,
    input  logic [THR_W-1:0] pd_thr,
    input  logic [SCL_W-1:0] sr_thr,
    input  logic [SCL_W-1:0] srg_thr,
    input  logic [SCL_W-1:0] srpd_thr,
    input  logic [THR_W-1:0] stby_thr,
    input  logic [1:0]       dram_kind,
    input  logic             exit_ack,
    output logic             enter_req,
    output logic [2:0]       enter_state,
    output logic             exit_req,
    output logic [2:0]       cur_state,
    output logic             ctl_clk_en,
    output logic             sys_clk_en,
    output logic             busy
);
    localparam int CNT_W = (THR_W > SCL_W + SHIFT) ? THR_W : SCL_W + SHIFT;

    logic [CNT_W-1:0] idle_cnt;
    logic [1:0]       kind_q;
    lp_state_e        target, state, ent_state;
    lp_phase_e        phase;
    clk_en_t          clk_en;
    logic             count_en, load;

    assign count_en = (phase == PH_RUN) && bus_idle && !wake_req;
    assign load     = (phase == PH_RUN) && (state == ST_ACTIVE);

    lp_idle_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .count_en (count_en),
        .cnt      (idle_cnt)
    );

    lp_level_pick #(
        .THR_W (THR_W),
        .SCL_W (SCL_W),
        .SHIFT (SHIFT),
        .CNT_W (CNT_W)
    ) u_pick (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .pd_thr    (pd_thr),
        .sr_thr    (sr_thr),
        .srg_thr   (srg_thr),
        .srpd_thr  (srpd_thr),
        .stby_thr  (stby_thr),
        .dram_kind (dram_kind),
        .cnt       (idle_cnt),
        .target    (target),
        .kind_q    (kind_q)
    );

    lp_state_ctrl u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .bus_idle    (bus_idle),
        .wake_req    (wake_req),
        .exit_ack    (exit_ack),
        .target      (target),
        .state       (state),
        .phase       (phase),
        .enter_req   (enter_req),
        .enter_state (ent_state),
        .exit_req    (exit_req),
        .clk_en      (clk_en)
    );

    assign cur_state   = state;
    assign enter_state = ent_state;
    assign ctl_clk_en  = clk_en.ctl;
    assign sys_clk_en  = clk_en.sys;
    assign busy        = (phase != PH_RUN);
endmodule

// File: rtl/lp_idle_seq_chk.sv
module lp_idle_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       enter_req,
    input logic [2:0] enter_state,
    input logic       exit_req,
    input logic [2:0] cur_state,
    input logic       ctl_clk_en,
    input logic       sys_clk_en,
    input logic       busy,
    input logic       exit_ack,
    input logic [1:0] kind_q
);
    a_r4_ctl_gated: assert property (@(posedge clk) disable iff (rst)
        (!busy && cur_state >= 3'd3) |=> !ctl_clk_en);

    a_r4_sys_gated: assert property (@(posedge clk) disable iff (rst)
        (!busy && cur_state == 3'd5) |=> !sys_clk_en);

    a_r9_restore_first: assert property (@(posedge clk) disable iff (rst)
        exit_req |-> (ctl_clk_en && sys_clk_en && $past(ctl_clk_en) && $past(sys_clk_en)));

    a_r9_exit_single: assert property (@(posedge clk) disable iff (rst)
        exit_req |=> !exit_req);

    a_r9_busy_until_ack: assert property (@(posedge clk) disable iff (rst)
        (busy && !exit_ack) |=> busy);

    a_r8_enter_deeper: assert property (@(posedge clk) disable iff (rst)
        enter_req |-> (enter_state == cur_state && cur_state > $past(cur_state)));

    a_r5_srpd_lp4: assert property (@(posedge clk) disable iff (rst)
        (cur_state == 3'd4) |-> (kind_q == 2'd2));

    a_r7_legal_code: assert property (@(posedge clk) disable iff (rst)
        cur_state <= 3'd5);
endmodule

bind lp_idle_seq lp_idle_seq_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .enter_req   (enter_req),
    .enter_state (enter_state),
    .exit_req    (exit_req),
    .cur_state   (cur_state),
    .ctl_clk_en  (ctl_clk_en),
    .sys_clk_en  (sys_clk_en),
    .busy        (busy),
    .exit_ack    (exit_ack),
    .kind_q      (kind_q)
);

// File: tb/lp_idle_seq_test.sv
`timescale 1ns/1ps
module lp_idle_seq_test;
    localparam int THR_W = 8;
    localparam int SCL_W = 4;
    localparam int SHIFT = 6;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic             rst, bus_idle, wake_req, exit_ack;
    logic [THR_W-1:0] pd_thr, stby_thr;
    logic [SCL_W-1:0] sr_thr, srg_thr, srpd_thr;
    logic [1:0]       dram_kind;
    logic             enter_req, exit_req, ctl_clk_en, sys_clk_en, busy;
    logic [2:0]       enter_state, cur_state;

    int n_chk = 0;
    int n_err = 0;

    lp_idle_seq #(.THR_W(THR_W), .SCL_W(SCL_W), .SHIFT(SHIFT)) uut (
        .clk(clk), .rst(rst), .bus_idle(bus_idle), .wake_req(wake_req),
        .pd_thr(pd_thr), .sr_thr(sr_thr), .srg_thr(srg_thr), .srpd_thr(srpd_thr),
        .stby_thr(stby_thr), .dram_kind(dram_kind), .exit_ack(exit_ack),
        .enter_req(enter_req), .enter_state(enter_state), .exit_req(exit_req),
        .cur_state(cur_state), .ctl_clk_en(ctl_clk_en), .sys_clk_en(sys_clk_en),
        .busy(busy)
    );

    typedef struct packed {
        logic [7:0] pd;
        logic [3:0] sr;
        logic [3:0] srg;
        logic [3:0] srpd;
        logic [7:0] stby;
        logic [1:0] kind;
        logic [9:0] n;
        logic [2:0] exp;
    } vec_t;

    // idle edges n; expected state is the deepest level whose limit <= n-1
    localparam vec_t VEC [12] = '{
        '{8'd5, 4'd0, 4'd0, 4'd0, 8'd0,   2'd0, 10'd4,   3'd0},
        '{8'd5, 4'd0, 4'd0, 4'd0, 8'd0,   2'd0, 10'd5,   3'd0},
        '{8'd5, 4'd1, 4'd0, 4'd0, 8'd0,   2'd0, 10'd70,  3'd2},
        '{8'd5, 4'd1, 4'd2, 4'd0, 8'd0,   2'd0, 10'd140, 3'd3},
        '{8'd5, 4'd1, 4'd2, 4'd3, 8'd0,   2'd2, 10'd200, 3'd4},
        '{8'd5, 4'd1, 4'd2, 4'd3, 8'd0,   2'd0, 10'd200, 3'd3},
        '{8'd5, 4'd1, 4'd2, 4'd3, 8'd0,   2'd1, 10'd200, 3'd3},
        '{8'd5, 4'd1, 4'd0, 4'd0, 8'd250, 2'd0, 10'd260, 3'd5},
        '{8'd5, 4'd0, 4'd0, 4'd0, 8'd0,   2'd0, 10'd100, 3'd1},
        '{8'd0, 4'd1, 4'd0, 4'd0, 8'd0,   2'd0, 10'd10,  3'd0},
        '{8'd0, 4'd0, 4'd1, 4'd0, 8'd0,   2'd0, 10'd70,  3'd3},
        '{8'd5, 4'd1, 4'd2, 4'd3, 8'd250, 2'd2, 10'd260, 3'd5}
    };

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic set_thr(input vec_t v);
        pd_thr    = v.pd;
        sr_thr    = v.sr;
        srg_thr   = v.srg;
        srpd_thr  = v.srpd;
        stby_thr  = v.stby;
        dram_kind = v.kind;
    endtask

    // called at a negedge with bus_idle or wake_req already set to stop
    task automatic exit_seq(input int st);
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R9 ctl_clk_en restored", int'(ctl_clk_en), 1);
        chk("R9 sys_clk_en restored", int'(sys_clk_en), 1);
        chk("R9 exit_req not yet", int'(exit_req), 0);
        @(posedge clk);
        @(negedge clk);
        chk("R9 exit_req strobe", int'(exit_req), 1);
        chk("R9 busy during exit", int'(busy), 1);
        @(posedge clk);
        @(negedge clk);
        chk("R9 exit_req single", int'(exit_req), 0);
        chk("R9 busy until ack", int'(busy), 1);
        chk("R9 state held until ack", int'(cur_state), st);
        exit_ack = 1'b1;
        @(posedge clk);
        @(negedge clk);
        exit_ack = 1'b0;
        chk("R9 active after ack", int'(cur_state), 0);
        chk("R9 busy cleared", int'(busy), 0);
    endtask

    task automatic idle_for(input int n);
        bus_idle = 1'b1;
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        rst = 1'b1; bus_idle = 1'b0; wake_req = 1'b0; exit_ack = 1'b0;
        set_thr('0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset state", int'(cur_state), 0);
        chk("R1 reset ctl_clk_en", int'(ctl_clk_en), 1);
        chk("R1 reset sys_clk_en", int'(sys_clk_en), 1);
        chk("R1 reset enter_req", int'(enter_req), 0);
        chk("R1 reset exit_req", int'(exit_req), 0);
        chk("R1 reset busy", int'(busy), 0);
        rst = 1'b0;

        // table: R2 R3 R5 R6 R7 (state), R4 (clock enables)
        for (int i = 0; i < 12; i++) begin
            set_thr(VEC[i]);
            repeat (2) @(posedge clk);
            @(negedge clk);
            idle_for(int'(VEC[i].n));
            chk($sformatf("R7 table vector %0d state", i), int'(cur_state), int'(VEC[i].exp));
            chk($sformatf("R4 table vector %0d ctl_clk_en", i), int'(ctl_clk_en),
                (VEC[i].exp < 3'd3) ? 1 : 0);
            chk($sformatf("R4 table vector %0d sys_clk_en", i), int'(sys_clk_en),
                (VEC[i].exp != 3'd5) ? 1 : 0);
            bus_idle = 1'b0;
            if (VEC[i].exp != 3'd0) begin
                exit_seq(int'(VEC[i].exp));
            end else begin
                repeat (2) @(posedge clk);
                @(negedge clk);
            end
        end

        // R2 and R8: power-down boundary and entry strobe
        set_thr('{8'd5, 4'd0, 4'd0, 4'd0, 8'd0, 2'd0, 10'd0, 3'd0});
        repeat (2) @(posedge clk);
        @(negedge clk);
        idle_for(6);
        chk("R2 power-down at limit", int'(cur_state), 1);
        chk("R8 enter_req raised", int'(enter_req), 1);
        chk("R8 enter_state code", int'(enter_state), 1);
        @(posedge clk);
        @(negedge clk);
        chk("R8 enter_req single cycle", int'(enter_req), 0);
        bus_idle = 1'b0;
        exit_seq(1);

        // R10: threshold edit while in power-down is ignored
        set_thr('{8'd5, 4'd1, 4'd0, 4'd0, 8'd0, 2'd0, 10'd0, 3'd0});
        repeat (2) @(posedge clk);
        @(negedge clk);
        idle_for(20);
        chk("R10 in power-down", int'(cur_state), 1);
        sr_thr = 4'd0;
        repeat (50) @(posedge clk);
        @(negedge clk);
        chk("R10 captured sr limit still used", int'(cur_state), 2);
        bus_idle = 1'b0;
        exit_seq(2);

        // R9: wake request while bus remains idle
        set_thr('{8'd5, 4'd0, 4'd0, 4'd0, 8'd0, 2'd0, 10'd0, 3'd0});
        repeat (2) @(posedge clk);
        @(negedge clk);
        idle_for(20);
        chk("R9 power-down before wake", int'(cur_state), 1);
        wake_req = 1'b1;
        exit_seq(1);
        repeat (10) @(posedge clk);
        @(negedge clk);
        chk("R9 wake holds active", int'(cur_state), 0);
        chk("R9 wake no entry strobe", int'(enter_req), 0);
        wake_req = 1'b0;
        bus_idle = 1'b0;

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule